// File: doc/BRIEF.md
# Serial Port Register and FIFO Front End

This block is the processor-facing half of a serial port. A simple 32-bit register bus reaches six word registers: a port that accepts bytes for transmission, a port that returns received bytes, a control word, a status word, a pair of interrupt levels and a baud word. Behind the bus the block keeps a transmit FIFO and a receive FIFO. Each FIFO is 64 bytes deep by default. The block also keeps sticky error flags and drives one interrupt line.

The bit engine and the baud generator are outside this block. The engine takes bytes from the transmit FIFO through a valid/take handshake. It pushes received bytes through a valid strobe and reports parity and framing errors with single-cycle strobes. It also reports whether it is still shifting. The block drives the baud word and the two direction enables to the engine.

Software clears the errors with a level-sensitive bit. The bit does not clear itself, so software must write it to 1 and then back to 0. Each direction also has its own level-sensitive reset bit. Each direction's interrupt fires at its own programmable FIFO level.

Top module: `sio_csr_front`

## Requirements
- R1: After reset, every register reads 0 except status. Status reads receive-empty (bit 20) = 1 and transmit-empty (bit 22) = 1. After reset, `irq` and `tx_valid` are 0.
- R2: A write to offset 0x00 appends `bus_wdata[7:0]` to the transmit FIFO. The engine sees the bytes in write order on `tx_data` while `tx_valid` is 1, and each cycle with `tx_take` = 1 removes one byte. `tx_valid` stays 0 while control bit 12 (transmit enable) is 0.
- R3: The transmit FIFO holds 64 bytes. With 64 bytes stored, status bit 21 (transmit full) is 1. A further write to 0x00 is discarded and sets sticky status bit 18 (overflow).
- R4: While control bit 13 (receive enable) is 1, `rx_valid` stores `rx_data` in the receive FIFO. A read of offset 0x04 returns the oldest byte in bits 7:0 (bits 31:8 zero) and removes it. A read with the FIFO empty returns 0. A push while receive enable is 0, or while the FIFO is full, is dropped.
- R5: `rx_par_err` sets status bit 16 and `rx_frm_err` sets status bit 17. Both flags, and bit 18, stay set until control bit 24 is 1. While bit 24 is held at 1, the flags read 0 even when new strobes arrive, and bit 24 reads back as 1.
- R6: While control bit 22 is 1, the transmit FIFO is emptied and `tx_valid` is 0. While control bit 23 is 1, the receive FIFO is emptied. The control, threshold and baud contents are unchanged.
- R7: With control bit 27 = 1, `irq` is 1 while the receive FIFO holds at least the level in threshold bits 7:0.
- R8: With control bit 28 = 1, `irq` is 1 while the transmit FIFO holds no more than the level in threshold bits 15:8.
- R9: Status bit 25 follows `tx_busy`. The transmitter is fully idle only when bit 22 = 1 and bit 25 = 0.
- R10: Offsets 0x08 and 0x14 read back the full written word, and offset 0x10 reads back bits 15:0 with the upper bits zero. `baud_word` equals the baud register, and `tx_enable`/`rx_enable` equal control bits 12/13. Read data appears on `bus_rdata` in the cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_data | output | 8 | Oldest byte of the transmit FIFO |
| tx_valid | output | 1 | Transmit byte available for the engine |
| tx_take | input | 1 | Engine removes the presented byte |
| tx_busy | input | 1 | Engine is shifting a byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_par_err | input | 1 | Parity error strobe |
| rx_frm_err | input | 1 | Framing error strobe |
| tx_enable | output | 1 | Transmit enable to the engine |
| rx_enable | output | 1 | Receive enable to the engine |
| baud_word | output | 32 | Baud register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is due one cycle after the read access, because `bus_rdata` is a register loaded at the access edge. The scoreboard queues each expected word when the read is driven and compares it at the falling edge after that access edge. Writes, pushes, pops and error strobes take effect at the edge where they are sampled. The interrupt line, `tx_valid` and `tx_data` are combinational from those registers, so the bench checks them at the falling edge that ends each access. Flags that take an extra edge to change, such as a reset bit emptying its FIFO, are checked only after an idle cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // word register byte offsets (software decodes these)
  localparam int unsigned OFS_TXP  = 0;
  localparam int unsigned OFS_RXP  = 4;
  localparam int unsigned OFS_CTL  = 8;
  localparam int unsigned OFS_STA  = 12;
  localparam int unsigned OFS_THR  = 16;
  localparam int unsigned OFS_BAUD = 20;

  // control bit positions
  localparam int unsigned CB_TXEN  = 12;
  localparam int unsigned CB_RXEN  = 13;
  localparam int unsigned CB_TXRST = 22;
  localparam int unsigned CB_RXRST = 23;
  localparam int unsigned CB_ECLR  = 24;
  localparam int unsigned CB_RXIE  = 27;
  localparam int unsigned CB_TXIE  = 28;

  // status bit positions
  localparam int unsigned SB_PAR  = 16;
  localparam int unsigned SB_FRM  = 17;
  localparam int unsigned SB_OVF  = 18;
  localparam int unsigned SB_RXE  = 20;
  localparam int unsigned SB_TXF  = 21;
  localparam int unsigned SB_TXE  = 22;
  localparam int unsigned SB_BUSY = 25;

  typedef struct packed {
    logic ovf;
    logic frm;
    logic par;
  } err_flags_t;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [DW-1:0]               din,
  input  logic                        pop,
  output logic [DW-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]  level,
  output logic                        full,
  output logic                        empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] lvl_q, lvl_n;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == CW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    lvl_n = lvl_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      lvl_n = '0;
    end else begin
      if (push_ok) wr_n = bump(wr_q);
      if (pop_ok)  rd_n = bump(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   lvl_n = lvl_q + 1'b1;
        2'b01:   lvl_n = lvl_q - 1'b1;
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign level = lvl_q;

  // R3: level never exceeds depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH));
  // R3: a full FIFO stays full when only pushes arrive
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  // R6: a held clear empties the FIFO
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/sio_csr.sv
module sio_csr
  import sio_pkg::*;
#(
  parameter int unsigned BUS_AW = 5,
  parameter int unsigned DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [DW-1:0]     rx_head,
  input  logic              rx_empty,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              busy,
  input  logic              par_stb,
  input  logic              frm_stb,
  output logic              tx_push,
  output logic              rx_pop,
  output logic              tx_en,
  output logic              rx_en,
  output logic              tx_rst,
  output logic              rx_rst,
  output logic              rx_ie,
  output logic              tx_ie,
  output logic [15:0]       thr,
  output logic [31:0]       baud
);
  logic [31:0] ctrl_q, rdata_q, rdata_n, sta;
  logic [15:0] thr_q;
  logic [31:0] baud_q;
  err_flags_t  err_q, err_n;
  logic        wr_ctl, wr_thr, wr_baud, rd_acc, hit_rxp, ovf_set;

  assign hit_rxp = (addr == BUS_AW'(OFS_RXP));
  assign rd_acc  = sel && !wr;
  assign wr_ctl  = sel && wr && (addr == BUS_AW'(OFS_CTL));
  assign wr_thr  = sel && wr && (addr == BUS_AW'(OFS_THR));
  assign wr_baud = sel && wr && (addr == BUS_AW'(OFS_BAUD));
  assign tx_push = sel && wr && (addr == BUS_AW'(OFS_TXP));
  assign rx_pop  = rd_acc && hit_rxp && !rx_empty && !ctrl_q[CB_RXRST];
  assign ovf_set = tx_push && tx_full && !ctrl_q[CB_TXRST];

  always_comb begin
    sta          = '0;
    sta[SB_PAR]  = err_q.par;
    sta[SB_FRM]  = err_q.frm;
    sta[SB_OVF]  = err_q.ovf;
    sta[SB_RXE]  = rx_empty;
    sta[SB_TXF]  = tx_full;
    sta[SB_TXE]  = tx_empty;
    sta[SB_BUSY] = busy;
  end

  always_comb begin
    rdata_n = '0;
    if (hit_rxp) begin
      if (!rx_empty) rdata_n = {{(32-DW){1'b0}}, rx_head};
    end else if (addr == BUS_AW'(OFS_CTL)) begin
      rdata_n = ctrl_q;
    end else if (addr == BUS_AW'(OFS_STA)) begin
      rdata_n = sta;
    end else if (addr == BUS_AW'(OFS_THR)) begin
      rdata_n = {16'h0, thr_q};
    end else if (addr == BUS_AW'(OFS_BAUD)) begin
      rdata_n = baud_q;
    end
  end

  always_comb begin
    if (ctrl_q[CB_ECLR]) begin
      err_n = '0;
    end else begin
      err_n.par = err_q.par | par_stb;
      err_n.frm = err_q.frm | frm_stb;
      err_n.ovf = err_q.ovf | ovf_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      thr_q   <= '0;
      baud_q  <= '0;
      rdata_q <= '0;
      err_q   <= '0;
    end else begin
      err_q <= err_n;
      if (wr_ctl)  ctrl_q  <= wdata;
      if (wr_thr)  thr_q   <= wdata[15:0];
      if (wr_baud) baud_q  <= wdata;
      if (rd_acc)  rdata_q <= rdata_n;
    end
  end

  assign rdata  = rdata_q;
  assign tx_en  = ctrl_q[CB_TXEN];
  assign rx_en  = ctrl_q[CB_RXEN];
  assign tx_rst = ctrl_q[CB_TXRST];
  assign rx_rst = ctrl_q[CB_RXRST];
  assign rx_ie  = ctrl_q[CB_RXIE];
  assign tx_ie  = ctrl_q[CB_TXIE];
  assign thr    = thr_q;
  assign baud   = baud_q;

  // R5: a held clear bit keeps every flag at zero
  a_r5_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_ECLR] |=> (err_q == '0));
  // R5: flags are sticky without the clear bit
  a_r5_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q.par && !ctrl_q[CB_ECLR]) |=> err_q.par);
  a_r5_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q.frm && !ctrl_q[CB_ECLR]) |=> err_q.frm);
  // R3: a write into a full transmit FIFO raises the overflow flag
  a_r3_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_rst && !ctrl_q[CB_ECLR]) |=> err_q.ovf);
  // R4: reading an empty receive port returns zero
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && hit_rxp && rx_empty) |=> (rdata_q == '0));
endmodule

// File: rtl/sio_irq.sv
module sio_irq #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_ie,
  input  logic          tx_ie,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  input  logic [15:0]   thr,
  output logic          irq
);
  localparam int unsigned LW = (CW > 8) ? CW : 8;

  logic [LW-1:0] rx_l, tx_l, rx_t, tx_t;
  logic          rx_hit, tx_hit;

  assign rx_l   = LW'(rx_level);
  assign tx_l   = LW'(tx_level);
  assign rx_t   = LW'(thr[7:0]);
  assign tx_t   = LW'(thr[15:8]);
  assign rx_hit = rx_ie && (rx_l >= rx_t);
  assign tx_hit = tx_ie && (tx_l <= tx_t);
  assign irq    = rx_hit || tx_hit;

  // R7/R8: no request while both enables are clear
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !tx_ie) |-> !irq);
  // R7: an empty receive FIFO raises no request with a non-zero level
  a_r7_rx_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie && rx_level == '0 && thr[7:0] != 8'h0) |-> !irq);
endmodule

// File: rtl/sio_csr_front.sv
module sio_csr_front
  import sio_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned BUS_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_take,
  input  logic              tx_busy,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic [31:0]       baud_word,
  output logic              irq
);
  localparam int unsigned DW = 8;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          tx_push, rx_pop, tx_en, rx_en, tx_rst, rx_rst, rx_ie, tx_ie;
  logic [15:0]   thr;
  logic [DW-1:0] rx_head, tx_head;
  logic [CW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_pop, rx_push;

  assign tx_valid = !tx_empty && tx_en && !tx_rst;
  assign tx_pop   = tx_valid && tx_take;
  assign rx_push  = rx_valid && rx_en && !rx_rst;

  sio_csr #(.BUS_AW(BUS_AW), .DW(DW)) u_csr (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .rx_head(rx_head),
    .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
    .busy(tx_busy), .par_stb(rx_par_err), .frm_stb(rx_frm_err),
    .tx_push(tx_push), .rx_pop(rx_pop), .tx_en(tx_en), .rx_en(rx_en),
    .tx_rst(tx_rst), .rx_rst(rx_rst), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .thr(thr), .baud(baud_word)
  );

  sio_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_rst), .push(tx_push), .din(bus_wdata[DW-1:0]),
    .pop(tx_pop), .dout(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sio_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_rst), .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sio_irq #(.CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_n), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .rx_level(rx_level), .tx_level(tx_level), .thr(thr), .irq(irq)
  );

  assign tx_data   = tx_head;
  assign tx_enable = tx_en;
  assign rx_enable = rx_en;

  // R2: nothing is offered to the engine while transmit is disabled
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_valid);
  // R4: a full receive FIFO stays full when a byte arrives and nothing is read
  a_r4_rx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_valid && !rx_pop && !rx_rst) |=> rx_full);
  // R6: a held transmit reset leaves the transmit FIFO empty
  a_r6_tx_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> tx_empty);
endmodule

// File: tb/sio_csr_front_tb_top.sv
module sio_csr_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  localparam logic [4:0] A_TXP = 5'h00, A_RXP = 5'h04, A_CTL = 5'h08,
                         A_STA = 5'h0C, A_THR = 5'h10, A_BAUD = 5'h14;
  localparam logic [31:0] C_TX = 32'h1 << 12, C_RX = 32'h1 << 13,
                          C_TR = 32'h1 << 22, C_RR = 32'h1 << 23,
                          C_EC = 32'h1 << 24, C_RI = 32'h1 << 27,
                          C_TI = 32'h1 << 28;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_take, tx_busy, rx_valid, rx_par_err, rx_frm_err;
  logic        tx_enable, rx_enable, irq;
  logic [31:0] baud_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend;

  sio_csr_front #(.DEPTH(DEPTH), .BUS_AW(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take), .tx_busy(tx_busy),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .tx_enable(tx_enable), .rx_enable(rx_enable),
    .baud_word(baud_word), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input bit p, input bit f, input bit o,
                                     input bit rxe, input bit txf, input bit txe,
                                     input bit bsy);
    logic [31:0] v;
    v = '0;
    v[16] = p; v[17] = f; v[18] = o; v[20] = rxe;
    v[21] = txf; v[22] = txe; v[25] = bsy;
    return v;
  endfunction

  // monitor: read data is due in the cycle after the access edge
  always @(posedge clk) rd_pend <= rst_n && bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", 32'h1, 32'h0);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic err_pulse(input bit p, input bit f);
    @(negedge clk);
    rx_par_err = p; rx_frm_err = f;
    @(negedge clk);
    rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic tx_pop(input logic [7:0] e, input string tag);
    @(negedge clk);
    chk({tag, " valid"}, {31'h0, tx_valid}, 32'h1);
    chk({tag, " byte"}, {24'h0, tx_data}, {24'h0, e});
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_take = 1'b0; tx_busy = 1'b0; rx_data = '0; rx_valid = 1'b0;
    rx_par_err = 1'b0; rx_frm_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R1 status");
    rd_exp(A_CTL, 32'h0, "R1 control");
    rd_exp(A_BAUD, 32'h0, "R1 baud");

    // R10 register readback and outputs
    wr_reg(A_CTL, C_TX | C_RX);
    wr_reg(A_THR, 32'hFFFF_0203);
    wr_reg(A_BAUD, 32'h00AB_CDEF);
    rd_exp(A_CTL, C_TX | C_RX, "R10 control");
    rd_exp(A_THR, 32'h0000_0203, "R10 threshold");
    rd_exp(A_BAUD, 32'h00AB_CDEF, "R10 baud");
    idle();
    chk("R10 baud_word", baud_word, 32'h00AB_CDEF);
    chk("R10 enables", {30'h0, tx_enable, rx_enable}, 32'h3);

    // R2 transmit order and byte lane
    wr_reg(A_TXP, 32'h0000_00A5);
    wr_reg(A_TXP, 32'h0000_003C);
    wr_reg(A_TXP, 32'hFFFF_FF77);
    tx_pop(8'hA5, "R2 first");
    tx_pop(8'h3C, "R2 second");
    tx_pop(8'h77, "R2 third");
    idle();
    chk("R2 drained", {31'h0, tx_valid}, 32'h0);
    wr_reg(A_CTL, C_RX);
    wr_reg(A_TXP, 32'h0000_0042);
    idle();
    chk("R2 disabled hold", {31'h0, tx_valid}, 32'h0);
    rd_exp(A_STA, st(0,0,0,1,0,0,0), "R2 byte kept while disabled");
    wr_reg(A_CTL, C_TX | C_RX);
    tx_pop(8'h42, "R2 after enable");

    // R3 depth and overflow
    wr_reg(A_CTL, C_RX);
    for (int i = 0; i < DEPTH; i++) wr_reg(A_TXP, 32'(i + 8'h40));
    rd_exp(A_STA, st(0,0,0,1,1,0,0), "R3 full");
    wr_reg(A_TXP, 32'h0000_00EE);
    rd_exp(A_STA, st(0,0,1,1,1,0,0), "R3 overflow flag");
    wr_reg(A_CTL, C_TX | C_RX);
    for (int i = 0; i < DEPTH; i++) tx_pop(8'(i + 8'h40), "R3 stored byte");
    idle();
    chk("R3 dropped byte absent", {31'h0, tx_valid}, 32'h0);

    // R5 sticky errors and level clear
    wr_reg(A_CTL, C_TX | C_RX | C_EC);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R5 overflow cleared");
    err_pulse(1, 1);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R5 held clear masks strobes");
    rd_exp(A_CTL, C_TX | C_RX | C_EC, "R5 clear bit stays set");
    wr_reg(A_CTL, C_TX | C_RX);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R5 nothing after release");
    err_pulse(1, 0);
    rd_exp(A_STA, st(1,0,0,1,0,1,0), "R5 parity");
    err_pulse(0, 1);
    idle();
    rd_exp(A_STA, st(1,1,0,1,0,1,0), "R5 parity and framing sticky");
    wr_reg(A_CTL, C_TX | C_RX | C_EC);
    wr_reg(A_CTL, C_TX | C_RX);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R5 cleared");

    // R4 receive path
    rx_put(8'h11);
    rx_put(8'h22);
    rd_exp(A_RXP, 32'h11, "R4 oldest");
    rd_exp(A_RXP, 32'h22, "R4 next");
    rd_exp(A_RXP, 32'h0, "R4 empty read");
    wr_reg(A_CTL, C_TX);
    rx_put(8'h99);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R4 disabled push ignored");
    wr_reg(A_CTL, C_TX | C_RX);
    for (int i = 0; i <= DEPTH; i++) rx_put(8'(i));
    for (int i = 0; i < DEPTH; i++) rd_exp(A_RXP, 32'(i), "R4 fill order");
    rd_exp(A_RXP, 32'h0, "R4 byte past full dropped");

    // R7 receive interrupt level (threshold 3)
    wr_reg(A_CTL, C_TX | C_RX | C_RI);
    rx_put(8'hA1);
    rx_put(8'hA2);
    chk("R7 below level", {31'h0, irq}, 32'h0);
    rx_put(8'hA3);
    chk("R7 at level", {31'h0, irq}, 32'h1);
    rd_exp(A_RXP, 32'hA1, "R7 read");
    chk("R7 after read", {31'h0, irq}, 32'h0);

    // R6 receive reset
    wr_reg(A_CTL, C_RX | C_RR);
    idle();
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R6 rx emptied");
    wr_reg(A_CTL, C_RX);
    rd_exp(A_RXP, 32'h0, "R6 rx read after reset");

    // R8 transmit interrupt level (threshold 2)
    wr_reg(A_CTL, C_RX | C_TI);
    chk("R8 empty fires", {31'h0, irq}, 32'h1);
    wr_reg(A_TXP, 32'h1);
    wr_reg(A_TXP, 32'h2);
    chk("R8 at level", {31'h0, irq}, 32'h1);
    wr_reg(A_TXP, 32'h3);
    chk("R8 above level", {31'h0, irq}, 32'h0);
    wr_reg(A_CTL, C_TX | C_RX | C_TI);
    tx_pop(8'h1, "R8 pop");
    chk("R8 back at level", {31'h0, irq}, 32'h1);

    // R6 transmit reset keeps registers
    wr_reg(A_CTL, C_RX);
    wr_reg(A_TXP, 32'h51);
    rx_put(8'h61);
    wr_reg(A_CTL, C_TX | C_RX | C_TR | C_RR);
    idle();
    chk("R6 tx_valid in reset", {31'h0, tx_valid}, 32'h0);
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R6 both emptied");
    rd_exp(A_CTL, C_TX | C_RX | C_TR | C_RR, "R6 control kept");
    rd_exp(A_THR, 32'h0000_0203, "R6 threshold kept");
    rd_exp(A_BAUD, 32'h00AB_CDEF, "R6 baud kept");
    wr_reg(A_CTL, C_TX | C_RX);
    wr_reg(A_TXP, 32'h5A);
    tx_pop(8'h5A, "R6 first after reset");
    rd_exp(A_RXP, 32'h0, "R6 rx stale byte gone");

    // R9 busy and idle
    tx_busy = 1'b1;
    idle();
    rd_exp(A_STA, st(0,0,0,1,0,1,1), "R9 busy shown");
    tx_busy = 1'b0;
    idle();
    rd_exp(A_STA, st(0,0,0,1,0,1,0), "R9 idle");

    repeat (3) idle();
    if (exp_q.size() != 0) chk("scoreboard leftover", 32'(exp_q.size()), 32'h0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule